// File: doc/BRIEF.md
# Transceiver lane power-up reset sequencer

This block takes a serial transceiver built from lane pairs out of its power-down and reset state in a fixed, timed order. When idle it accepts a start pulse. It then drives every lane power-down, every lane reset and every pair PLL reset active together, and holds a captured configuration word on its output. After that it releases the controls one group at a time.

For each lane pair in turn, starting with pair 0, three groups are released: first the pair's two power-downs, then the PLL reset the pair shares, and then the pair's two lane resets. A fixed wait of `WAIT_CYCLES` clocks follows the initial all-assert phase and each release step. The default value is 3000, which is 15 µs at 200 MHz. With the default two pairs there are six release steps and seven waits. When the last wait runs out, `busy` falls and `done` pulses for one cycle. The controls stay released until the next start.

Top module: `lane_rst_seq`

## Requirements
- R1: After reset, busy and done are 0, every lane_pd, lane_rst and pll_rst bit is 1, and cfg_out is 0.
- R2: A start seen while idle makes busy 1 from the next cycle, with every lane_pd, lane_rst and pll_rst bit at 1 and cfg_out equal to the cfg_in value present at that start.
- R3: The sequence has 3*NUM_PAIRS+1 phases, and each phase lasts exactly WAIT_CYCLES clocks. Phase k (k = 0 is the all-assert phase) covers clock cycles k*WAIT_CYCLES through (k+1)*WAIT_CYCLES-1, counted from the cycle after start.
- R4: For pair p, whose lanes are 2p and 2p+1 and whose PLL reset is pll_rst[p], phase 3p+1 clears the pair's lane_pd bits, phase 3p+2 clears pll_rst[p], and phase 3p+3 clears the pair's lane_rst bits. A cleared bit stays cleared until the sequence ends.
- R5: Pair p+1 releases nothing until every control of pair p has been released.
- R6: In the cycle after the last phase ends, busy is 0 and done is 1. done is 0 in the following cycles, and all controls stay cleared until a new start.
- R7: A start seen while busy is ignored: phase timing, controls and cfg_out continue as if it never happened.
- R8: cfg_out does not change while busy, even if cfg_in changes.
- R9: A start after done begins a new sequence, with all controls asserted again and the new cfg_in captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence when idle |
| cfg_in | input | CFG_W | Static configuration word captured at start |
| cfg_out | output | CFG_W | Captured configuration word |
| lane_pd | output | 2*NUM_PAIRS | Per-lane power-down, active high |
| lane_rst | output | 2*NUM_PAIRS | Per-lane reset, active high |
| pll_rst | output | NUM_PAIRS | Per-pair PLL reset, active high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
The hardest case to reach is a second start that lands in the middle of a sequence, together with a change of cfg_in. Nothing at the ports shows the block's internal phase, so such a start is invisible unless it disturbs timing or the captured word. To reach it, the bench overrides the wait to a few cycles. It pulses start with a different cfg_in part-way through a sequence and then changes cfg_in again. It checks every cycle of the whole sequence against a precomputed per-cycle expectation, so any shift in phase boundaries or in cfg_out is caught. A start issued right after done covers the re-entry from the fully released state.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    // Which group of a lane pair a release step acts on; the value is the
    // step offset within that pair's three steps.
    typedef enum logic [1:0] {
        REL_PWR  = 2'd1,
        REL_PLL  = 2'd2,
        REL_LANE = 2'd3
    } rel_kind_e;

    localparam int unsigned STEPS_PER_PAIR = 3;

    // Phase index in which the given group of the given pair is released.
    function automatic int unsigned release_phase(int unsigned pair, rel_kind_e kind);
        return STEPS_PER_PAIR * pair + int'(kind);
    endfunction

endpackage

// File: rtl/lrs_wait_timer.sv
module lrs_wait_timer #(
    parameter int unsigned WAIT_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int unsigned CW = $clog2(WAIT_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Last cycle of a loaded interval.
    assign expire = (cnt_q == CW'(1));

    // R3: an interval just loaded cannot end in the next cycle unless it is one clock long
    a_r3_no_early_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (load && WAIT_CYCLES > 1) |=> !expire);

endmodule

// File: rtl/lrs_release_map.sv
module lrs_release_map #(
    parameter int unsigned NUM_PAIRS = 2,
    parameter int unsigned SW        = 3
) (
    input  logic [SW-1:0]          phase,
    output logic [2*NUM_PAIRS-1:0] lane_pd,
    output logic [2*NUM_PAIRS-1:0] lane_rst,
    output logic [NUM_PAIRS-1:0]   pll_rst
);
    import lrs_pkg::*;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int unsigned PWR_AT  = release_phase(p, REL_PWR);
        localparam int unsigned PLL_AT  = release_phase(p, REL_PLL);
        localparam int unsigned LANE_AT = release_phase(p, REL_LANE);

        // A group stays asserted until the sequence reaches its release phase.
        assign lane_pd[2*p +: 2]  = {2{32'(phase) < PWR_AT}};
        assign pll_rst[p]         = (32'(phase) < PLL_AT);
        assign lane_rst[2*p +: 2] = {2{32'(phase) < LANE_AT}};
    end

endmodule

// File: rtl/lane_rst_seq.sv
module lane_rst_seq #(
    parameter int unsigned NUM_PAIRS   = 2,
    parameter int unsigned CFG_W       = 8,
    parameter int unsigned WAIT_CYCLES = 3000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CFG_W-1:0]       cfg_in,
    output logic [CFG_W-1:0]       cfg_out,
    output logic [2*NUM_PAIRS-1:0] lane_pd,
    output logic [2*NUM_PAIRS-1:0] lane_rst,
    output logic [NUM_PAIRS-1:0]   pll_rst,
    output logic                   busy,
    output logic                   done
);
    localparam int unsigned NSTEPS = lrs_pkg::STEPS_PER_PAIR * NUM_PAIRS;
    localparam int unsigned SW     = $clog2(NSTEPS + 1);
    localparam logic [SW-1:0] LAST_PHASE = SW'(NSTEPS);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [SW-1:0]    phase;
        logic [CFG_W-1:0] cfg;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       load_d;
    logic       expire;

    lrs_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_d),
        .expire (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load_d    = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.phase = '0;
                st_d.cfg   = cfg_in;
                load_d     = 1'b1;
            end
        end else if (expire) begin
            if (st_q.phase == LAST_PHASE) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
                load_d     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lrs_release_map #(.NUM_PAIRS(NUM_PAIRS), .SW(SW)) u_map (
        .phase    (st_q.phase),
        .lane_pd  (lane_pd),
        .lane_rst (lane_rst),
        .pll_rst  (pll_rst)
    );

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign cfg_out = st_q.cfg;

    // R6: done lasts a single cycle and marks the fall of busy
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R2: every control is asserted when a sequence begins
    a_r2_start_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (&lane_pd && &lane_rst && &pll_rst));
    // R8: captured word does not move while busy
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_out));

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_order
        // R4: PLL released only after the pair's power-downs; lanes only after the PLL
        a_r4_pll_after_pwr: assert property (@(posedge clk) disable iff (!rst_n)
            !pll_rst[p] |-> (lane_pd[2*p +: 2] == 2'b00));
        a_r4_lane_after_pll: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_rst[2*p +: 2] == 2'b00) |-> !pll_rst[p]);
        if (p > 0) begin : g_prev
            // R5: a later pair starts only once the earlier pair is fully out of reset
            a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
                (lane_pd[2*p +: 2] != 2'b11) |-> (lane_rst[2*(p-1) +: 2] == 2'b00));
        end
    end

endmodule

// File: tb/sim_lane_rst_seq.sv
`timescale 1ns/1ps
module sim_lane_rst_seq;
    localparam int NP = 2;
    localparam int NL = 2 * NP;
    localparam int CW = 8;
    localparam int W  = 4;
    localparam int NPH = 3 * NP + 1;
    localparam int SEQ = NPH * W;

    typedef struct {
        logic          busy;
        logic          done;
        logic [NL-1:0] pd;
        logic [NL-1:0] rst;
        logic [NP-1:0] pll;
        logic [CW-1:0] cfg;
        string         req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic [CW-1:0] cfg_in;
    logic [CW-1:0] cfg_out;
    logic [NL-1:0] lane_pd, lane_rst;
    logic [NP-1:0] pll_rst;
    logic busy, done;

    int checks = 0;
    int failures = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    lane_rst_seq #(.NUM_PAIRS(NP), .CFG_W(CW), .WAIT_CYCLES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .cfg_out(cfg_out), .lane_pd(lane_pd), .lane_rst(lane_rst),
        .pll_rst(pll_rst), .busy(busy), .done(done)
    );

    // Expected outputs j cycles after the start edge (j = 0 is the cycle right after it).
    function automatic exp_t model(int j, logic [CW-1:0] c, string tag);
        exp_t e;
        int s;
        s = (j < SEQ) ? j / W : NPH - 1;
        e.busy = (j < SEQ);
        e.done = (j == SEQ);
        for (int l = 0; l < NL; l++) begin
            e.pd[l]  = (s < 3 * (l / 2) + 1);
            e.rst[l] = (s < 3 * (l / 2) + 3);
        end
        for (int p = 0; p < NP; p++) e.pll[p] = (s < 3 * p + 2);
        e.cfg = c;
        if (j == 0)        e.req = {tag, " R2"};
        else if (j < SEQ)  e.req = {tag, " R3 R4 R5"};
        else               e.req = {tag, " R6"};
        return e;
    endfunction

    // Monitor: compare each cycle against the next queued expectation.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (busy !== e.busy || done !== e.done || lane_pd !== e.pd ||
                lane_rst !== e.rst || pll_rst !== e.pll || cfg_out !== e.cfg) begin
                failures++;
                $display("FAIL %s: busy/done/pd/rst/pll/cfg actual %b %b %h %h %h %h expected %b %b %h %h %h %h",
                         e.req, busy, done, lane_pd, lane_rst, pll_rst, cfg_out,
                         e.busy, e.done, e.pd, e.rst, e.pll, e.cfg);
            end
        end
    end

    // Driver: start a sequence, queue every expected cycle, optionally disturb it.
    task automatic run_seq(logic [CW-1:0] c, bit disturb, string tag);
        cfg_in = c;
        start  = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        for (int j = 0; j <= SEQ + 3; j++) sb.push_back(model(j, c, tag));
        if (disturb) begin
            repeat (5) @(posedge clk);
            #1;
            cfg_in = ~c;              // R7: start while busy must be ignored
            start  = 1'b1;
            @(posedge clk); #1;
            start  = 1'b0;
            repeat (3) @(posedge clk);
            #1;
            cfg_in = 8'h5A;           // R8: cfg_in change while busy
        end
        wait (sb.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic check_r1;
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || lane_pd !== '1 || lane_rst !== '1 ||
            pll_rst !== '1 || cfg_out !== '0) begin
            failures++;
            $display("FAIL R1: busy/done/pd/rst/pll/cfg actual %b %b %h %h %h %h expected 0 0 f f 3 00",
                     busy, done, lane_pd, lane_rst, pll_rst, cfg_out);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual hung expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n  = 1'b0;
        start  = 1'b0;
        cfg_in = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_r1();                       // R1 reset state
        @(posedge clk); #1;
        run_seq(8'hA5, 1'b0, "R2");       // plain sequence
        run_seq(8'h3C, 1'b1, "R7 R8");    // start and cfg_in change mid-sequence
        run_seq(8'hC1, 1'b0, "R9");       // restart from fully released state
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule